// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Controller

This block is the cycle-accurate control path of a flow-through synchronous SRAM with one shared data bus. On each rising clock edge it samples three chip selects, two address strobes and the address. The processor strobe and the controller strobe follow different rules, and from them the block decides whether a new access begins. It holds the captured address, turns the global-write and per-byte write inputs into a byte-lane write mask for a small behavioural memory, and produces the enable for the data-bus output drivers.

A processor-strobe access only captures its address on the starting edge. Any write for it happens on a later edge, at the held address. A controller-strobe access can write on its starting edge, using the address presented on that edge. Read data flows through from the memory at the held address without an extra register stage. It is driven only while output enable is active and no write is requested. The bus is shown as a separate data-out and a drive-enable pair, so that a pad ring or a test model can form the tristate.

All control inputs are active low except `cs2_i`, which is active high. Data byte k occupies bits [8k+7:8k] of the data bus and is selected by `bsel_ni[k]`.

Top module: `sync_burst_sram_ctrl`

## Requirements
- R1: When `cs1_ni`=0, `cs2_i`=1 and `cs3_ni`=0 at a rising edge, and a strobe event is present, the address is captured and an access becomes active. A strobe event is a processor strobe that is not ignored, or `cstb_ni`=0. A strobe event with any chip select inactive ends the current access, and the outputs then stay tristated.
- R2: While `cs1_ni`=1, `pstb_ni` has no effect: with `cstb_ni`=1 the held address and the access state are unchanged.
- R3: While `pstb_ni`=0 and `cs1_ni`=0, `cstb_ni` is ignored. The edge is a processor-strobe start, and it writes nothing even if the write inputs are active.
- R4: On a processor-strobe start edge the write inputs are ignored. On each later edge of the active access with no strobe event, active write inputs write `dq_i` at the captured address.
- R5: On a controller-strobe start edge with the write inputs active, `dq_i` is written to the address presented on that edge.
- R6: A controller-strobe start with the write inputs inactive is a read and modifies no memory byte.
- R7: `gw_ni`=0 writes all four bytes, whatever the states of `bwe_ni` and `bsel_ni`.
- R8: With `gw_ni`=1, byte k is written only when `bwe_ni`=0 and `bsel_ni[k]`=0. Every other byte keeps its value.
- R9: `dq_oe_o` is 0 in any cycle in which the write inputs request a write (`gw_ni`=0, or `bwe_ni`=0 with some `bsel_ni` bit 0), whatever the state of `oe_ni`.
- R10: `dq_oe_o` is 1 exactly when an access is active, `oe_ni`=0 and no write is requested. `dq_o` then carries the memory word at the held address, and it is 0 whenever `dq_oe_o` is 0.
- R11: After reset no access is active, `dq_oe_o` is 0 and every memory word reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs1_ni | input | 1 | First chip select, active low; gates the processor strobe |
| cs2_i | input | 1 | Second chip select, active high |
| cs3_ni | input | 1 | Third chip select, active low |
| pstb_ni | input | 1 | Processor address strobe, active low |
| cstb_ni | input | 1 | Controller address strobe, active low |
| addr_i | input | ADDR_W | Word address |
| gw_ni | input | 1 | Global write, active low, all bytes |
| bwe_ni | input | 1 | Byte write enable, active low |
| bsel_ni | input | BYTES | Per-byte select, active low |
| oe_ni | input | 1 | Output enable, active low |
| dq_i | input | BYTES*BYTE_W | Write data from the shared bus |
| dq_o | output | BYTES*BYTE_W | Read data toward the shared bus |
| dq_oe_o | output | 1 | Output driver enable for the shared bus |

## Verification
On every cycle the bound checker confirms these properties: the drivers stay off when a write is requested or output enable is high; a processor-strobe start never writes; writes follow the global and per-byte rules; every start captures its address; and a raised first chip select freezes the access state. The memory contents cannot be seen by those properties. For that, the bench scenarios write words and read them back. These scenarios show that a controller-strobe write lands on its starting edge, that a processor-strobe write lands only on the next edge, that partial byte writes leave the other bytes intact, and that a suppressed write really changed nothing.

// File: rtl/sbsc_pkg.sv
package sbsc_pkg;
   typedef struct packed {
      logic evt;      // a strobe is honoured this edge
      logic sel;      // all chip selects active
      logic p_start;  // processor-strobe start
      logic c_start;  // controller-strobe start
   } sbsc_evt_t;
endpackage

// File: rtl/sbsc_access_decode.sv
module sbsc_access_decode
   import sbsc_pkg::*;
(
   input  logic      cs1_ni,
   input  logic      cs2_i,
   input  logic      cs3_ni,
   input  logic      pstb_ni,
   input  logic      cstb_ni,
   output sbsc_evt_t ev_o
);
   logic p_ev, c_ev;
   always_comb begin
      p_ev = !pstb_ni && !cs1_ni;       // processor strobe gated by first select
      c_ev = !cstb_ni && !p_ev;         // controller strobe yields to processor strobe
      ev_o.sel     = !cs1_ni && cs2_i && !cs3_ni;
      ev_o.evt     = p_ev || c_ev;
      ev_o.p_start = p_ev && ev_o.sel;
      ev_o.c_start = c_ev && ev_o.sel;
   end
endmodule

// File: rtl/sbsc_byte_write.sv
module sbsc_byte_write #(
   parameter int BYTES = 4
) (
   input  logic             gw_ni,
   input  logic             bwe_ni,
   input  logic [BYTES-1:0] bsel_ni,
   input  logic             allow_i,
   output logic             wreq_o,
   output logic [BYTES-1:0] mask_o
);
   logic [BYTES-1:0] req_mask;
   for (genvar k = 0; k < BYTES; k++) begin : g_lane
      assign req_mask[k] = !gw_ni || (!bwe_ni && !bsel_ni[k]);
   end
   assign wreq_o = |req_mask;
   assign mask_o = allow_i ? req_mask : '0;
endmodule

// File: rtl/sbsc_mem.sv
module sbsc_mem #(
   parameter int    ADDR_W    = 4,
   parameter int    BYTES     = 4,
   parameter int    BYTE_W    = 8,
   parameter bit    CLEAR_RST = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [BYTES-1:0]        we_i,
   input  logic [ADDR_W-1:0]       waddr_i,
   input  logic [BYTES*BYTE_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0]       raddr_i,
   output logic [BYTES*BYTE_W-1:0] rdata_o
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar k = 0; k < BYTES; k++) begin : g_lane
      logic [BYTE_W-1:0] lane [DEPTH];
      if (CLEAR_RST) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) lane[i] <= '0;
            end else if (we_i[k]) begin
               lane[waddr_i] <= wdata_i[k*BYTE_W +: BYTE_W];
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (we_i[k]) lane[waddr_i] <= wdata_i[k*BYTE_W +: BYTE_W];
         end
      end
      assign rdata_o[k*BYTE_W +: BYTE_W] = lane[raddr_i];
   end
endmodule

// File: rtl/sync_burst_sram_ctrl.sv
module sync_burst_sram_ctrl
   import sbsc_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int BYTES     = 4,
   parameter int BYTE_W    = 8,
   parameter bit CLEAR_RST = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cs1_ni,
   input  logic                    cs2_i,
   input  logic                    cs3_ni,
   input  logic                    pstb_ni,
   input  logic                    cstb_ni,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic                    gw_ni,
   input  logic                    bwe_ni,
   input  logic [BYTES-1:0]        bsel_ni,
   input  logic                    oe_ni,
   input  logic [BYTES*BYTE_W-1:0] dq_i,
   output logic [BYTES*BYTE_W-1:0] dq_o,
   output logic                    dq_oe_o
);
   localparam int DW = BYTES * BYTE_W;

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("ADDR_W must lie in 1..12");
   end
   if (BYTES < 1 || BYTE_W < 1) begin : g_bad_width
      $error("BYTES and BYTE_W must be positive");
   end

   sbsc_evt_t         ev;
   logic              acc_active;
   logic [ADDR_W-1:0] acc_addr;
   logic              wr_allow;
   logic              wr_req;
   logic [BYTES-1:0]  wr_mask;
   logic [ADDR_W-1:0] wr_addr;
   logic [DW-1:0]     rd_data;

   sbsc_access_decode dec_i (
      .cs1_ni (cs1_ni), .cs2_i (cs2_i), .cs3_ni (cs3_ni),
      .pstb_ni(pstb_ni), .cstb_ni(cstb_ni), .ev_o(ev)
   );

   // controller start writes at once; otherwise only an ongoing access writes
   assign wr_allow = ev.c_start || (!ev.evt && acc_active);
   assign wr_addr  = ev.c_start ? addr_i : acc_addr;

   sbsc_byte_write #(.BYTES(BYTES)) bw_i (
      .gw_ni(gw_ni), .bwe_ni(bwe_ni), .bsel_ni(bsel_ni),
      .allow_i(wr_allow), .wreq_o(wr_req), .mask_o(wr_mask)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_active <= 1'b0;
         acc_addr   <= '0;
      end else if (ev.evt) begin
         acc_active <= ev.sel;
         if (ev.sel) acc_addr <= addr_i;
      end
   end

   sbsc_mem #(
      .ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W), .CLEAR_RST(CLEAR_RST)
   ) mem_i (
      .clk(clk), .rst_n(rst_n), .we_i(wr_mask), .waddr_i(wr_addr),
      .wdata_i(dq_i), .raddr_i(acc_addr), .rdata_o(rd_data)
   );

   assign dq_oe_o = acc_active && !oe_ni && !wr_req;
   assign dq_o    = dq_oe_o ? rd_data : '0;
endmodule

// File: rtl/sbsc_checker.sv
module sbsc_checker #(
   parameter int ADDR_W = 4,
   parameter int BYTES  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs1_ni,
   input logic              cs2_i,
   input logic              cs3_ni,
   input logic              pstb_ni,
   input logic              cstb_ni,
   input logic [ADDR_W-1:0] addr_i,
   input logic              gw_ni,
   input logic              bwe_ni,
   input logic [BYTES-1:0]  bsel_ni,
   input logic              oe_ni,
   input logic              dq_oe_o,
   input logic [BYTES-1:0]  wmask,
   input logic              active,
   input logic [ADDR_W-1:0] areg
);
   logic sel_all, strobe_seen, wr_asked;
   assign sel_all     = !cs1_ni && cs2_i && !cs3_ni;
   assign strobe_seen = (!pstb_ni && !cs1_ni) || !cstb_ni;
   assign wr_asked    = !gw_ni || (!bwe_ni && !(&bsel_ni));

   assert_start_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
      sel_all && strobe_seen |=> active && areg == $past(addr_i));
   assert_cs1_freezes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cs1_ni && cstb_ni |=> $stable(active) && $stable(areg));
   assert_pstb_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cs1_ni && !pstb_ni |-> wmask == '0);
   assert_gw_all_bytes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !gw_ni && wmask != '0 |-> &wmask);
   assert_unselected_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      gw_ni |-> (wmask & (bsel_ni | {BYTES{bwe_ni}})) == '0);
   assert_write_tristate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_asked |-> !dq_oe_o);
   assert_oe_high_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      oe_ni || !active |-> !dq_oe_o);
endmodule

bind sync_burst_sram_ctrl sbsc_checker #(.ADDR_W(ADDR_W), .BYTES(BYTES)) chk_i (
   .clk(clk), .rst_n(rst_n), .cs1_ni(cs1_ni), .cs2_i(cs2_i), .cs3_ni(cs3_ni),
   .pstb_ni(pstb_ni), .cstb_ni(cstb_ni), .addr_i(addr_i), .gw_ni(gw_ni),
   .bwe_ni(bwe_ni), .bsel_ni(bsel_ni), .oe_ni(oe_ni), .dq_oe_o(dq_oe_o),
   .wmask(wr_mask), .active(acc_active), .areg(acc_addr)
);

// File: tb/sync_burst_sram_ctrl_tb_top.sv
module sync_burst_sram_ctrl_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs1_ni = 1, cs2_i = 0, cs3_ni = 1, pstb_ni = 1, cstb_ni = 1;
   logic [3:0] addr_i = '0;
   logic gw_ni = 1, bwe_ni = 1, oe_ni = 1;
   logic [3:0] bsel_ni = 4'hF;
   logic [31:0] dq_i = '0;
   logic [31:0] dq_o;
   logic dq_oe_o;

   int checks = 0, failures = 0;
   logic [31:0] m_mem [16];
   logic        m_act;
   logic [3:0]  m_addr;

   always #2 clk = ~clk;

   sync_burst_sram_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cs1_ni(cs1_ni), .cs2_i(cs2_i), .cs3_ni(cs3_ni),
      .pstb_ni(pstb_ni), .cstb_ni(cstb_ni), .addr_i(addr_i), .gw_ni(gw_ni),
      .bwe_ni(bwe_ni), .bsel_ni(bsel_ni), .oe_ni(oe_ni), .dq_i(dq_i),
      .dq_o(dq_o), .dq_oe_o(dq_oe_o)
   );

   function automatic logic [3:0] exp_mask(logic g, logic b, logic [3:0] s);
      return !g ? 4'hF : (!b ? ~s : 4'h0);
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // apply inputs at negedge, check pre-edge outputs, update model at posedge
   task automatic step(string tag, logic c1, logic c2, logic c3, logic p, logic c,
                       logic [3:0] a, logic g, logic b, logic [3:0] s, logic o,
                       logic [31:0] d);
      logic [3:0] mk;
      logic pe, ce, sel, eo;
      cs1_ni = c1; cs2_i = c2; cs3_ni = c3; pstb_ni = p; cstb_ni = c;
      addr_i = a; gw_ni = g; bwe_ni = b; bsel_ni = s; oe_ni = o; dq_i = d;
      #1;
      mk = exp_mask(g, b, s);
      eo = m_act && !o && (mk == 4'h0);
      chk({tag, (mk != 0) ? " R9 oe" : " R10 oe"}, {31'b0, dq_oe_o}, {31'b0, eo});
      chk({tag, " R10 data"}, dq_o, eo ? m_mem[m_addr] : 32'h0);
      @(posedge clk);
      sel = !c1 && c2 && !c3;
      pe  = !p && !c1;
      ce  = !c && !pe;
      if (pe || ce) begin
         if (sel && ce)
            for (int k = 0; k < 4; k++) if (mk[k]) m_mem[a][k*8 +: 8] = d[k*8 +: 8];
         if (sel) m_addr = a;
         m_act = sel;
      end else if (m_act) begin
         for (int k = 0; k < 4; k++) if (mk[k]) m_mem[m_addr][k*8 +: 8] = d[k*8 +: 8];
      end
      @(negedge clk);
   endtask

   task automatic idle(string tag, logic o);
      step(tag, 0, 1, 0, 1, 1, 4'h0, 1, 1, 4'hF, o, 32'h0);
   endtask

   // controller-strobe read start, then compare against a hand-computed word
   task automatic readback(string tag, logic [3:0] a, logic [31:0] exp);
      step({tag, " R6 start"}, 0, 1, 0, 1, 0, a, 1, 1, 4'hF, 1, 32'h0);
      idle(tag, 0);
      #1 chk({tag, " readback"}, dq_o, exp);
   endtask

   initial begin
      #800000;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd1237));
      for (int i = 0; i < 16; i++) m_mem[i] = '0;
      m_act = 0; m_addr = 0;
      @(negedge clk); @(negedge clk);
      #1;
      chk("R11 reset oe", {31'b0, dq_oe_o}, 32'h0);
      chk("R11 reset data", dq_o, 32'h0);
      rst_n = 1;
      @(negedge clk);

      // R5: controller-strobe write on its starting edge
      step("R5 cstb write", 0, 1, 0, 1, 0, 4'h3, 0, 1, 4'hF, 1, 32'h11223344);
      readback("R5", 4'h3, 32'h11223344);
      readback("R11 cleared", 4'h9, 32'h0);
      // R4: processor start ignores write inputs, next edge writes
      step("R4 pstb start", 0, 1, 0, 0, 1, 4'h5, 0, 1, 4'hF, 1, 32'hAAAAAAAA);
      step("R4 follow write", 0, 1, 0, 1, 1, 4'h0, 0, 1, 4'hF, 1, 32'h55667788);
      readback("R4", 4'h5, 32'h55667788);
      step("R4 pstb only", 0, 1, 0, 0, 1, 4'h6, 0, 1, 4'hF, 1, 32'hDEADBEEF);
      idle("R4 no follow", 1);
      readback("R4 ignored", 4'h6, 32'h0);
      // R8: bytes 0 and 2 selected
      step("R8 byte write", 0, 1, 0, 1, 0, 4'h3, 1, 0, 4'b1010, 1, 32'hFFFFFFFF);
      readback("R8", 4'h3, 32'h11FF33FF);
      step("R8 bwe off", 0, 1, 0, 1, 1, 4'h0, 1, 1, 4'h0, 1, 32'hFFFFFFFF);
      readback("R8 no bwe", 4'h3, 32'h11FF33FF);
      // R7: global write on the ongoing access at word 3
      step("R7 global", 0, 1, 0, 1, 1, 4'h0, 0, 1, 4'hF, 1, 32'h0A0B0C0D);
      readback("R7", 4'h3, 32'h0A0B0C0D);
      // R2: first select high, processor strobe low -> nothing changes
      step("R2 cs1 high", 1, 1, 0, 0, 1, 4'h9, 1, 1, 4'hF, 0, 32'h0);
      idle("R2 held", 0);
      #1 chk("R2 held word", dq_o, 32'h0A0B0C0D);
      // R3: both strobes, write inputs active -> processor start, no write
      step("R3 both strobes", 0, 1, 0, 0, 0, 4'h7, 0, 1, 4'hF, 1, 32'h12345678);
      idle("R3", 0);
      #1 chk("R3 no write", dq_o, 32'h0);
      // R9: write requested while output enable active
      step("R9 write vs oe", 0, 1, 0, 1, 1, 4'h0, 1, 0, 4'b1110, 0, 32'h000000EE);
      readback("R9", 4'h7, 32'h000000EE);
      // R1: strobe with second select inactive ends the access
      step("R1 deselect", 0, 0, 0, 1, 0, 4'h2, 1, 1, 4'hF, 0, 32'h0);
      idle("R1 after", 0);
      #1 chk("R1 deselected", {31'b0, dq_oe_o}, 32'h0);

      // constrained random traffic
      for (int n = 0; n < 600; n++) begin
         logic c1, c2, c3, p, c, g, b, o;
         c1 = ($urandom_range(0, 9) < 2);
         c2 = ($urandom_range(0, 9) >= 1);
         c3 = ($urandom_range(0, 9) < 1);
         p  = ($urandom_range(0, 9) >= 2);
         c  = ($urandom_range(0, 9) >= 3);
         g  = ($urandom_range(0, 9) >= 2);
         b  = ($urandom_range(0, 9) >= 5);
         o  = ($urandom_range(0, 9) < 3);
         step("R1 R10 random", c1, c2, c3, p, c, 4'($urandom_range(0, 15)), g, b,
              4'($urandom_range(0, 15)), o, $urandom);
      end
      for (int i = 0; i < 16; i++) readback("R8 final", 4'(i), m_mem[i]);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule